// File: doc/BRIEF.md
# PCIe Root Port Bring-Up Sequencer

This block takes a single-lane PCIe root port from cold reset to a trained link. After a start command it drives the port's control pins in a fixed order. First it pulls the slot reset low for a timed interval and then releases it. Next it powers the slot, takes the PHY out of its test power-down and turns on the reference clock. It waits for the clocks to settle and then lets the link training state machine run. Finally it samples a link-up status at regular intervals, for a bounded number of tries. The result is reported on two sticky flags: link good or link failed.

All intervals are counted in pulses of a tick input, not in clock cycles. The system chooses the time base and the tick counts through parameters. The defaults assume a 1 µs tick: a 100 ms reset pulse, a 150 µs settling wait (inside the required 100–200 µs window), a 100 ms poll interval and ten tries. The sequencer can be restarted from idle or from either finished state. A start that arrives while a sequence is running is ignored.

Top module: `pcie_bringup_seq`

## Requirements
- R1: Out of reset the outputs are: `perst_n_o`=0, `ep_disable_o`=1, `phy_tpd_o`=1, and `pwr_en_o`, `refclk_en_o`, `ltssm_en_o`, `link_good_o` and `link_fail_o` all 0.
- R2: A start seen at a clock edge while idle, good or failed gives these values from the next cycle on: `perst_n_o`=0, `phy_tpd_o`=1, `ep_disable_o`=1, and `pwr_en_o`=`refclk_en_o`=`ltssm_en_o`=0 with both result flags cleared.
- R3: `perst_n_o` stays low until RESET_TICKS ticks have been sampled after the start cycle. It goes high in the cycle after the edge that samples the last of those ticks.
- R4: One cycle after `perst_n_o` rises, `pwr_en_o` and `refclk_en_o` go to 1, and `phy_tpd_o` and `ep_disable_o` go to 0.
- R5: `ltssm_en_o` rises in the cycle after SETTLE_TICKS further ticks have been sampled, counted from the cycle in which power came up. It is never high unless power, the reference clock and the released reset are all active and the PHY is out of power-down.
- R6: After `ltssm_en_o` rises, `link_up_i` is sampled at the edge of every POLL_TICKS-th tick. If it is 1 at a sample, `link_good_o` is 1 from the next cycle on.
- R7: If the link is still down at the MAX_TRIES-th sample, `link_fail_o` is 1 from the next cycle on. Both flags hold until the next accepted start and are never high together.
- R8: A start during the reset, power-up, settling or polling phases has no effect on any output.
- R9: `link_up_i` is ignored in every cycle that is not a sample point, including cycles where it pulses high between ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start (or restart) the bring-up sequence |
| tick_i | input | 1 | One-cycle time-base pulse; all delays count these |
| link_up_i | input | 1 | Link-up status from the controller core |
| perst_n_o | output | 1 | Slot reset, active low |
| pwr_en_o | output | 1 | Slot power enable |
| phy_tpd_o | output | 1 | PHY test power-down |
| refclk_en_o | output | 1 | Reference clock enable |
| ltssm_en_o | output | 1 | Link training enable |
| ep_disable_o | output | 1 | Endpoint disable, active high |
| link_good_o | output | 1 | Link came up within the allowed tries |
| link_fail_o | output | 1 | Link never came up |

## Verification
The hardest situation to reach is a link-up that is high only between sample points. Such a pulse must have no effect, and the run must still end in failure after the last try. The stimulus gets there by driving `link_up_i` as the inverse of `tick_i` for a whole sequence. Random tick spacing and random starts during busy phases are layered over directed runs. Those runs succeed on an early try, succeed on the last try, fail outright, and restart from each finished state.

// File: rtl/pcie_bringup_seq.sv
module pcie_bringup_seq #(
  parameter int RESET_TICKS  = 100000,
  parameter int SETTLE_TICKS = 150,
  parameter int POLL_TICKS   = 100000,
  parameter int MAX_TRIES    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic tick_i,
  input  logic link_up_i,
  output logic perst_n_o,
  output logic pwr_en_o,
  output logic phy_tpd_o,
  output logic refclk_en_o,
  output logic ltssm_en_o,
  output logic ep_disable_o,
  output logic link_good_o,
  output logic link_fail_o
);

  localparam int LONG1   = (RESET_TICKS > POLL_TICKS) ? RESET_TICKS : POLL_TICKS;
  localparam int LONGEST = (LONG1 > SETTLE_TICKS) ? LONG1 : SETTLE_TICKS;
  localparam int CW      = $clog2(LONGEST + 1);
  localparam int TW      = $clog2(MAX_TRIES + 1);
  localparam logic [CW-1:0] RST_LAST  = CW'(RESET_TICKS - 1);
  localparam logic [CW-1:0] SET_LAST  = CW'(SETTLE_TICKS - 1);
  localparam logic [CW-1:0] POLL_LAST = CW'(POLL_TICKS - 1);
  localparam logic [TW-1:0] TRY_LAST  = TW'(MAX_TRIES - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_PWR, S_SETTLE, S_POLL, S_GOOD, S_FAIL
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tries;
  logic          busy;
  logic          accept;

  assign busy   = (st == S_RST) || (st == S_PWR) || (st == S_SETTLE) || (st == S_POLL);
  assign accept = start_i && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      tries        <= '0;
      perst_n_o    <= 1'b0;
      pwr_en_o     <= 1'b0;
      phy_tpd_o    <= 1'b1;
      refclk_en_o  <= 1'b0;
      ltssm_en_o   <= 1'b0;
      ep_disable_o <= 1'b1;
      link_good_o  <= 1'b0;
      link_fail_o  <= 1'b0;
    end else if (accept) begin
      st           <= S_RST;
      cnt          <= '0;
      tries        <= '0;
      perst_n_o    <= 1'b0;
      pwr_en_o     <= 1'b0;
      phy_tpd_o    <= 1'b1;
      refclk_en_o  <= 1'b0;
      ltssm_en_o   <= 1'b0;
      ep_disable_o <= 1'b1;
      link_good_o  <= 1'b0;
      link_fail_o  <= 1'b0;
    end else begin
      case (st)
        S_RST: if (tick_i) begin
          if (cnt == RST_LAST) begin
            cnt       <= '0;
            perst_n_o <= 1'b1;
            st        <= S_PWR;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PWR: begin
          pwr_en_o     <= 1'b1;
          phy_tpd_o    <= 1'b0;
          refclk_en_o  <= 1'b1;
          ep_disable_o <= 1'b0;
          st           <= S_SETTLE;
        end
        S_SETTLE: if (tick_i) begin
          if (cnt == SET_LAST) begin
            cnt        <= '0;
            tries      <= '0;
            ltssm_en_o <= 1'b1;
            st         <= S_POLL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_POLL: if (tick_i) begin
          if (cnt == POLL_LAST) begin
            cnt   <= '0;
            tries <= tries + 1'b1;
            if (link_up_i) begin
              link_good_o <= 1'b1;
              st          <= S_GOOD;
            end else if (tries == TRY_LAST) begin
              link_fail_o <= 1'b1;
              st          <= S_FAIL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pcie_bringup_seq_chk.sv
module pcie_bringup_seq_chk #(
  parameter int RESET_TICKS = 100000
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic tick_i,
  input logic perst_n_o,
  input logic pwr_en_o,
  input logic phy_tpd_o,
  input logic refclk_en_o,
  input logic ltssm_en_o,
  input logic link_good_o,
  input logic link_fail_o,
  input logic busy
);

  int low_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_ticks <= 0;
    else if (start_i && !busy)           low_ticks <= 0;
    else if (tick_i && busy && !perst_n_o) low_ticks <= low_ticks + 1;
  end

  AST_RST_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perst_n_o) |-> low_ticks == RESET_TICKS); // R3

  AST_PWR_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en_o) |-> perst_n_o && $past(perst_n_o)); // R4

  AST_LTSSM_PRECOND: assert property (@(posedge clk) disable iff (!rst_n)
    ltssm_en_o |-> (refclk_en_o && pwr_en_o && !phy_tpd_o && perst_n_o)); // R5

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_good_o && link_fail_o)); // R7

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail_o && !start_i |=> link_fail_o); // R7

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start_i && perst_n_o |=> perst_n_o); // R8

endmodule

bind pcie_bringup_seq pcie_bringup_seq_chk #(.RESET_TICKS(RESET_TICKS)) u_chk (.*);

// File: tb/pcie_bringup_seq_test.sv
`timescale 1ns/1ps
module pcie_bringup_seq_test;

  localparam int RT = 6;
  localparam int ST = 4;
  localparam int PT = 5;
  localparam int MT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, tick = 1'b0, link = 1'b0;
  logic perst_n, pwr_en, tpd, refclk, ltssm, epdis, good, fail;

  always #2.5 clk = ~clk;

  pcie_bringup_seq #(.RESET_TICKS(RT), .SETTLE_TICKS(ST), .POLL_TICKS(PT), .MAX_TRIES(MT)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick), .link_up_i(link),
    .perst_n_o(perst_n), .pwr_en_o(pwr_en), .phy_tpd_o(tpd), .refclk_en_o(refclk),
    .ltssm_en_o(ltssm), .ep_disable_o(epdis), .link_good_o(good), .link_fail_o(fail));

  int checks = 0, fails = 0;
  bit finished = 0;

  // reference: phase 0 idle, 1 reset, 2 power, 3 settle, 4 poll, 5 good, 6 fail
  int ph = 0, mc = 0, mtr = 0;
  logic e_perst = 0, e_pwr = 0, e_tpd = 1, e_ref = 0, e_lt = 0, e_epd = 1, e_good = 0, e_fail = 0;

  function automatic bit m_busy();
    return ph >= 1 && ph <= 4;
  endfunction

  function automatic void model(input logic s, input logic t, input logic l);
    if (s && !m_busy()) begin
      ph = 1; mc = 0; mtr = 0;
      e_perst = 0; e_pwr = 0; e_tpd = 1; e_ref = 0; e_lt = 0; e_epd = 1; e_good = 0; e_fail = 0;
    end else if (ph == 1) begin
      if (t) begin mc++; if (mc == RT) begin mc = 0; e_perst = 1; ph = 2; end end
    end else if (ph == 2) begin
      e_pwr = 1; e_tpd = 0; e_ref = 1; e_epd = 0; ph = 3;
    end else if (ph == 3) begin
      if (t) begin mc++; if (mc == ST) begin mc = 0; mtr = 0; e_lt = 1; ph = 4; end end
    end else if (ph == 4) begin
      if (t) begin
        mc++;
        if (mc == PT) begin
          mc = 0; mtr++;
          if (l) begin e_good = 1; ph = 5; end
          else if (mtr == MT) begin e_fail = 1; ph = 6; end
        end
      end
    end
  endfunction

  task automatic field(input string tag, input string nm, input logic a, input logic e, inout bit bad);
    if (a !== e) begin
      $display("FAIL %s %s act=%b exp=%b at %0t", tag, nm, a, e, $time);
      bad = 1;
    end
  endtask

  task automatic compare(input string over);
    bit bad = 0;
    checks++;
    field(over != "" ? over : "R3", "perst_n", perst_n, e_perst, bad);
    field(over != "" ? over : "R4", "pwr_en", pwr_en, e_pwr, bad);
    field(over != "" ? over : "R4", "phy_tpd", tpd, e_tpd, bad);
    field(over != "" ? over : "R4", "refclk_en", refclk, e_ref, bad);
    field(over != "" ? over : "R4", "ep_disable", epdis, e_epd, bad);
    field(over != "" ? over : "R5", "ltssm_en", ltssm, e_lt, bad);
    field(over != "" ? over : "R6", "link_good", good, e_good, bad);
    field(over != "" ? over : "R7", "link_fail", fail, e_fail, bad);
    if (bad) fails++;
  endtask

  task automatic step(input logic s, input logic t, input logic l, input string tag);
    start = s; tick = t; link = l;
    @(posedge clk);
    model(s, t, l);
    @(negedge clk);
    compare(tag);
  endtask

  // up_at: sample index (1-based) from which link_up is held high; 0 = never
  // glitch: link_up high only in cycles without a tick (R9)
  task automatic run(input int up_at, input bit glitch, input int tick_pct, input int start_pct);
    int guard = 0;
    step(1'b1, 1'b0, 1'b0, "R2");
    while (m_busy() && guard < 20000) begin
      logic t, s, l;
      guard++;
      t = ($urandom % 100) < tick_pct;
      s = ($urandom % 100) < start_pct;
      if (glitch) l = !t;
      else l = (up_at != 0) && (ph == 4) && (mtr + 1 >= up_at);
      step(s, t, l, s ? "R8" : (glitch ? "R9" : ""));
    end
    repeat (3) step(1'b0, ($urandom % 2) == 1, 1'b0, "R7");
  endtask

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    step(1'b0, 1'b1, 1'b1, "R1");

    // directed: dense ticks, link up at third sample
    run(3, 0, 100, 0);
    if (good !== 1'b1) begin fails++; $display("FAIL R6 link_good act=%b exp=1", good); end
    checks++;
    // directed: link up exactly at the last try
    run(MT, 0, 100, 0);
    checks++;
    if (good !== 1'b1) begin fails++; $display("FAIL R6 last-try act=%b exp=1", good); end
    // directed: link never up
    run(0, 0, 100, 0);
    checks++;
    if (fail !== 1'b1) begin fails++; $display("FAIL R7 link_fail act=%b exp=1", fail); end
    // restart from failure with glitchy link between sample points
    run(0, 1, 50, 0);
    checks++;
    if (fail !== 1'b1 || good !== 1'b0) begin
      fails++; $display("FAIL R9 good/fail act=%b%b exp=01", good, fail);
    end
    // random: sparse ticks, starts while busy, random up point
    for (int i = 0; i < 12; i++) run(($urandom % (MT + 2)), 0, 20 + ($urandom % 60), 5);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule